// File: doc/BRIEF.md
# Protocol Discovery Responder

This block answers protocol discovery requests arriving through a request-object mailbox. When `start` is pulsed, it reads the request's length dword and index dword from a request buffer through a registered read port with one cycle of latency. It then writes a three-dword response object into a response buffer and pulses `done`. The `rsp_valid` flag shows whether a response was produced or the request was discarded.

The supported protocols are given as a parameter table of {vendor, type} pairs. The discovery protocol itself always occupies index 0, and table entry k is reported at index k+1. Software walks the list by sending the returned next index back in the following request, until that index wraps to 0. The total protocol count, discovery included, must stay below 256.

Top module: `disc_resp_top`

## Requirements
- R1: After reset, `done` and `rsp_wr_en` are low.
- R2: A request whose length field (request dword 1, bits 17:0) is below 3 is discarded: `done` pulses with `rsp_valid` low and no response dword is written.
- R3: A valid response dword 0 is 0x00000001 (vendor 0x0001 in bits 15:0, type 0x00 in bits 23:16), and dword 1 is 3.
- R4: Requested index 0 (request dword 2, bits 7:0) reports vendor 0x0001 and type 0x00 in response dword 2 (vendor in bits 15:0, type in bits 23:16).
- R5: An index i with 1 <= i <= NUM_ENTRIES reports table entry i-1. Each entry is a 24-bit {type[7:0], vendor[15:0]} slice of `PROTO_TABLE`.
- R6: An index at or beyond the total count (NUM_ENTRIES+1) reports vendor 0xFFFF and type 0xFF.
- R7: Response dword 2 bits 31:24 hold (index+1) modulo the total count.
- R8: A valid response writes addresses 0, 1 and 2 on consecutive cycles. `done` is high for exactly one cycle, in the same cycle as the write to address 2.
- R9: A `start` pulse that arrives while a request is in progress is ignored and produces no extra response.
- R10: A length field of 3 or more is accepted, including lengths above 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin processing the request held in the buffer |
| req_rd_addr | output | REQ_AW | Request buffer read address (registered) |
| req_rd_data | input | 32 | Request buffer read data, one cycle after the address |
| rsp_wr_en | output | 1 | Response buffer write strobe |
| rsp_wr_addr | output | 2 | Response dword index |
| rsp_wr_data | output | 32 | Response dword |
| done | output | 1 | One-cycle completion pulse |
| rsp_valid | output | 1 | 1 = response written, 0 = request discarded; meaningful with done |

## Verification
The index is swept over 0, every table position, the first out-of-range value, a large value (200) and 255. Together these separate the discovery self-entry, the off-by-one table mapping, the all-ones fallback, and the wrap of the next index, including the case where index+1 overflows eight bits. Lengths 0 and 2 against lengths 3 and 5 locate the discard threshold. A second start pulse issued mid-request shows whether busy starts leak into extra responses. Every done event is matched against a queued expectation, so missing or surplus completions also show up.

// File: rtl/disc_pkg.sv
package disc_pkg;
  localparam int DW        = 32;
  localparam int IDX_W     = 8;
  localparam int LEN_W     = 18;
  localparam int RSP_WORDS = 3;
  localparam int RSP_AW    = 2;
  localparam logic [15:0] SELF_VENDOR = 16'h0001;
  localparam logic [7:0]  SELF_TYPE   = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR1, ST_LEN, ST_IDX, ST_W0, ST_W1, ST_W2
  } disc_state_e;
endpackage

// File: rtl/disc_lookup.sv
module disc_lookup #(
  parameter int NUM_ENTRIES = 2,
  parameter logic [NUM_ENTRIES*24-1:0] PROTO_TABLE = {24'h02_1E98, 24'h01_0001}
) (
  input  logic [disc_pkg::IDX_W-1:0] idx_i,
  output logic [15:0]                vendor_o,
  output logic [7:0]                 type_o,
  output logic [disc_pkg::IDX_W-1:0] next_o
);
  import disc_pkg::*;
  localparam logic [IDX_W:0] TOTAL = (IDX_W+1)'(NUM_ENTRIES + 1);

  logic [NUM_ENTRIES-1:0] hit;
  logic [15:0] ent_v [NUM_ENTRIES];
  logic [7:0]  ent_t [NUM_ENTRIES];

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_ent
    assign hit[k]   = (idx_i == IDX_W'(k + 1));
    assign ent_v[k] = hit[k] ? PROTO_TABLE[k*24 +: 16] : 16'h0000;
    assign ent_t[k] = hit[k] ? PROTO_TABLE[k*24+16 +: 8] : 8'h00;
  end

  logic [IDX_W:0] sum, rem;

  always_comb begin
    vendor_o = 16'h0000;
    type_o   = 8'h00;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      vendor_o = vendor_o | ent_v[k];
      type_o   = type_o | ent_t[k];
    end
    if (idx_i == '0) begin
      vendor_o = SELF_VENDOR;
      type_o   = SELF_TYPE;
    end else if ({1'b0, idx_i} >= TOTAL) begin
      vendor_o = 16'hFFFF;
      type_o   = 8'hFF;
    end
    sum    = {1'b0, idx_i} + 1'b1;
    rem    = sum % TOTAL;
    next_o = rem[IDX_W-1:0];
  end
endmodule

// File: rtl/disc_emit.sv
module disc_emit (
  input  logic [disc_pkg::RSP_AW-1:0] sel_i,
  input  logic [15:0]                 vendor_i,
  input  logic [7:0]                  type_i,
  input  logic [disc_pkg::IDX_W-1:0]  next_i,
  output logic [disc_pkg::DW-1:0]     dword_o
);
  import disc_pkg::*;
  always_comb begin
    case (sel_i)
      2'd0:    dword_o = {8'h00, SELF_TYPE, SELF_VENDOR};
      2'd1:    dword_o = DW'(RSP_WORDS);
      2'd2:    dword_o = {next_i, type_i, vendor_i};
      default: dword_o = '0;
    endcase
  end
endmodule

// File: rtl/disc_ctrl.sv
module disc_ctrl #(
  parameter int REQ_AW = 8,
  parameter int TOTAL  = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  output logic [REQ_AW-1:0]           rd_addr_o,
  input  logic [disc_pkg::DW-1:0]     rd_data_i,
  output logic [disc_pkg::IDX_W-1:0]  idx_o,
  output logic [disc_pkg::RSP_AW-1:0] sel_o,
  input  logic [disc_pkg::DW-1:0]     dword_i,
  output logic                        wr_en_o,
  output logic [disc_pkg::RSP_AW-1:0] wr_addr_o,
  output logic [disc_pkg::DW-1:0]     wr_data_o,
  output logic                        done_o,
  output logic                        valid_o
);
  import disc_pkg::*;

  disc_state_e     st;
  logic [LEN_W-1:0] len_q;

  always_comb begin
    case (st)
      ST_W1:   sel_o = 2'd1;
      ST_W2:   sel_o = 2'd2;
      default: sel_o = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      rd_addr_o <= '0;
      len_q     <= '0;
      idx_o     <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      wr_en_o <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          rd_addr_o <= REQ_AW'(1);
          st        <= ST_ADDR1;
        end
        ST_ADDR1: begin
          rd_addr_o <= REQ_AW'(2);
          st        <= ST_LEN;
        end
        ST_LEN: begin
          len_q <= rd_data_i[LEN_W-1:0];
          st    <= ST_IDX;
        end
        ST_IDX: begin
          if (len_q < LEN_W'(RSP_WORDS)) begin
            done_o  <= 1'b1;
            valid_o <= 1'b0;
            st      <= ST_IDLE;
          end else begin
            idx_o <= rd_data_i[IDX_W-1:0];
            st    <= ST_W0;
          end
        end
        ST_W0, ST_W1, ST_W2: begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= sel_o;
          wr_data_o <= dword_i;
          if (st == ST_W2) begin
            done_o  <= 1'b1;
            valid_o <= 1'b1;
            st      <= ST_IDLE;
          end else if (st == ST_W0) begin
            st <= ST_W1;
          end else begin
            st <= ST_W2;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R2
  discard_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !valid_o) |-> !wr_en_o);
  // R8
  last_write_done_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_addr_o == 2'd2) |-> (done_o && valid_o));
  // R8
  write_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_addr_o == 2'd0) |=> (wr_en_o && wr_addr_o == 2'd1));
  // R3
  hdr_len_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_addr_o == 2'd1) |-> (wr_data_o == 32'd3));
  // R7
  next_range_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_addr_o == 2'd2) |-> (int'(wr_data_o[31:24]) < TOTAL));
endmodule

// File: rtl/disc_resp_top.sv
module disc_resp_top #(
  parameter int REQ_AW      = 8,
  parameter int NUM_ENTRIES = 2,
  parameter logic [NUM_ENTRIES*24-1:0] PROTO_TABLE = {24'h02_1E98, 24'h01_0001}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [REQ_AW-1:0] req_rd_addr,
  input  logic [31:0]       req_rd_data,
  output logic              rsp_wr_en,
  output logic [1:0]        rsp_wr_addr,
  output logic [31:0]       rsp_wr_data,
  output logic              done,
  output logic              rsp_valid
);
  import disc_pkg::*;
  localparam int TOTAL = NUM_ENTRIES + 1;

  logic [IDX_W-1:0]  idx, nxt;
  logic [15:0]       vendor;
  logic [7:0]        ptype;
  logic [RSP_AW-1:0] sel;
  logic [DW-1:0]     dword;

  disc_ctrl #(.REQ_AW(REQ_AW), .TOTAL(TOTAL)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start),
    .rd_addr_o(req_rd_addr), .rd_data_i(req_rd_data),
    .idx_o(idx), .sel_o(sel), .dword_i(dword),
    .wr_en_o(rsp_wr_en), .wr_addr_o(rsp_wr_addr), .wr_data_o(rsp_wr_data),
    .done_o(done), .valid_o(rsp_valid)
  );

  disc_lookup #(.NUM_ENTRIES(NUM_ENTRIES), .PROTO_TABLE(PROTO_TABLE)) u_lookup (
    .idx_i(idx), .vendor_o(vendor), .type_o(ptype), .next_o(nxt)
  );

  disc_emit u_emit (
    .sel_i(sel), .vendor_i(vendor), .type_i(ptype), .next_i(nxt), .dword_o(dword)
  );
endmodule

// File: tb/disc_resp_top_bench.sv
module disc_resp_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0]  req_rd_addr;
  logic [31:0] req_rd_data = '0;
  logic        rsp_wr_en, done, rsp_valid;
  logic [1:0]  rsp_wr_addr;
  logic [31:0] rsp_wr_data;

  always #2 clk = ~clk;

  disc_resp_top u_disc_resp_top (
    .clk(clk), .rst(rst), .start(start),
    .req_rd_addr(req_rd_addr), .req_rd_data(req_rd_data),
    .rsp_wr_en(rsp_wr_en), .rsp_wr_addr(rsp_wr_addr), .rsp_wr_data(rsp_wr_data),
    .done(done), .rsp_valid(rsp_valid)
  );

  logic [31:0] req_mem [8];
  always @(posedge clk) req_rd_data <= req_mem[req_rd_addr[2:0]];

  typedef struct {
    bit          valid;
    logic [31:0] d2;
    string       rq;
  } exp_t;
  exp_t exp_q[$];

  int nchk = 0, nfail = 0, nwr = 0;
  logic [31:0] cap [4];
  bit prev_done = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Expected dword 2 from the requirements (table: {01,0001},{02,1E98}; total 3)
  function automatic logic [31:0] exp_d2(input int idx);
    logic [15:0] v; logic [7:0] t; int nx;
    if (idx == 0) begin v = 16'h0001; t = 8'h00; end
    else if (idx == 1) begin v = 16'h0001; t = 8'h01; end
    else if (idx == 2) begin v = 16'h1E98; t = 8'h02; end
    else begin v = 16'hFFFF; t = 8'hFF; end
    nx = (idx + 1) % 3;
    return {nx[7:0], t, v};
  endfunction

  // Monitor: compares results against the queue as they appear
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_wr_en) begin
        cap[rsp_wr_addr] = rsp_wr_data;
        nwr++;
      end
      if (done && prev_done) chk(1'b0, "R8 done longer than one cycle", 32'd1, 32'd0);
      if (done && !prev_done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rsp_valid == e.valid, {e.rq, " valid flag"}, 32'(rsp_valid), 32'(e.valid));
          if (e.valid) begin
            chk(nwr == 3, "R8 write count", nwr, 3);
            chk(cap[0] == 32'h00000001, "R3 dword0", cap[0], 32'h00000001);
            chk(cap[1] == 32'd3, "R3 dword1", cap[1], 32'd3);
            chk(cap[2] == e.d2, {e.rq, " dword2"}, cap[2], e.d2);
          end else begin
            chk(nwr == 0, "R2 discard writes", nwr, 0);
          end
        end
        nwr = 0;
      end
      prev_done = done;
    end
  end

  task automatic run_req(input logic [31:0] len, input int idx, input bit valid,
                         input string rq, input bit extra_start);
    exp_t e;
    req_mem[0] = 32'h00000001;
    req_mem[1] = len;
    req_mem[2] = 32'(idx);
    e.valid = valid; e.d2 = exp_d2(idx); e.rq = rq;
    exp_q.push_back(e);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (extra_start) begin
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) req_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", 32'(done), 0);
    chk(rsp_wr_en == 1'b0, "R1 wr_en after reset", 32'(rsp_wr_en), 0);

    run_req(32'd3, 0,   1'b1, "R4 index0", 1'b0);
    run_req(32'd3, 1,   1'b1, "R5 index1", 1'b0);
    run_req(32'd3, 2,   1'b1, "R5 index2", 1'b0);
    run_req(32'd3, 3,   1'b1, "R6 index3", 1'b0);
    run_req(32'd3, 200, 1'b1, "R6 R7 index200", 1'b0);
    run_req(32'd3, 255, 1'b1, "R7 index255", 1'b0);
    run_req(32'd2, 1,   1'b0, "R2 len2", 1'b0);
    run_req(32'd0, 0,   1'b0, "R2 len0", 1'b0);
    run_req(32'd5, 1,   1'b1, "R10 len5", 1'b0);
    run_req(32'd3, 2,   1'b1, "R9 busy start", 1'b1);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all requests completed", exp_q.size(), 0);
    finish_run();
  end
endmodule